// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial memory protocol engine and gathers the data bytes of one write sequence into a page-sized staging buffer. The engine tells it where the sequence starts by loading a word address. It then hands over each received data byte with a strobe and reports start and stop conditions. Bytes land at consecutive offsets inside the addressed page. The offset wraps within the page, so a sequence longer than one page overwrites its own earlier bytes.

A stop condition is the only event that commits the buffer. On stop, and only if at least one byte was collected and the write-protect input is low, the block walks the page offsets in ascending order. It issues one array write for each location that received a byte and leaves the other locations untouched. It then holds a busy flag for a parameterised write-cycle time. While busy is high the block ignores every input, and the protocol engine uses the flag to refuse new transfers. A start condition that arrives before stop discards the collected bytes. With write-protect high the bytes are still taken but never written.

Top module: `page_commit_buf`

## Requirements
- R1: After synchronous reset, `busy_o` and `mem_we_o` are low and the staging buffer is empty.
- R2: An address load sets the page row to the upper `ROW_W` bits and the in-page offset to the lower `OFS_W` bits of `load_addr_val_i`. Each accepted byte is stored at the current offset, and the offset then increments.
- R3: Only the offset increments. It wraps from `PAGE_BYTES-1` to 0 while the row stays fixed. When a sequence carries more than `PAGE_BYTES` bytes, the last byte sent to an offset is the one written.
- R4: No array write occurs before a stop. The commit starts in the clock cycle after the stop is sampled. Offset k is presented on the write port in the k-th cycle of the commit, counting from 0, so the writes come in ascending offset order.
- R5: During a commit, exactly the offsets that received a byte are written, each once. No other location of the array is written.
- R6: After a committing stop, `busy_o` is high for exactly `PAGE_BYTES + WRITE_CYCLES` cycles, starting in the cycle after the stop is sampled. Array writes occur only while `busy_o` is high.
- R7: While `busy_o` is high, address loads, data bytes, starts and stops have no effect. A later stop with no new bytes commits nothing, and the busy window is not extended.
- R8: If `wr_lock_i` is high when a stop is sampled, nothing is written, `busy_o` stays low and the collected bytes are dropped.
- R9: A start strobe before stop discards all collected bytes. A following stop then writes nothing and raises no busy window.
- R10: A stop with no collected bytes, for example after an address load alone, writes nothing and leaves `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_addr_i | input | 1 | Strobe: load start word address |
| load_addr_val_i | input | ADDR_W | Word address: row in the upper bits, in-page offset in the lower bits |
| byte_stb_i | input | 1 | Strobe: one data byte received |
| byte_i | input | 8 | Data byte |
| start_stb_i | input | 1 | Strobe: start condition seen on the link |
| stop_stb_i | input | 1 | Strobe: stop condition seen on the link |
| wr_lock_i | input | 1 | Write-protect level, sampled with the stop |
| mem_we_o | output | 1 | Array write enable, one byte per cycle |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Commit or write cycle in progress |

## Verification
The stop is sampled on a rising edge E0. Busy is visible from the falling edge after E0, and it stays high on exactly `PAGE_BYTES + WRITE_CYCLES` falling edges. Offset k appears on the write port on the (k+1)-th of those edges. The bench drives every strobe at a falling edge and samples at falling edges. It counts busy falling edges from the stop and checks each offset the write port shows against that count. A shadow array collects the writes, and the bench compares it with its own page model only after busy has dropped. For the cases that must not commit, the bench checks busy and the write count on the first falling edge after the stop.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_COMMIT = 2'd1,
        PH_SETTLE = 2'd2
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic load;
        logic data;
    } strobe_s;

    function automatic int unsigned busy_span(input int unsigned page_bytes,
                                              input int unsigned settle);
        return page_bytes + settle;
    endfunction

    function automatic strobe_s gate_strobes(input strobe_s raw, input logic open);
        strobe_s g;
        g.start = raw.start & open;
        g.stop  = raw.stop  & open & ~raw.start;
        g.load  = raw.load  & open & ~raw.start & ~raw.stop;
        g.data  = raw.data  & open & ~raw.start & ~raw.stop & ~raw.load;
        return g;
    endfunction

endpackage

// File: rtl/pcb_cursor.sv
module pcb_cursor #(
    parameter int unsigned OFS_W = 6,
    parameter int unsigned ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] load_row,
    input  logic [OFS_W-1:0] load_ofs,
    input  logic             adv,
    output logic [ROW_W-1:0] row,
    output logic [OFS_W-1:0] ofs
);

    logic [ROW_W-1:0] row_q;
    logic [OFS_W-1:0] ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            ofs_q <= '0;
        end else if (load) begin
            row_q <= load_row;
            ofs_q <= load_ofs;
        end else if (adv) begin
            ofs_q <= ofs_q + OFS_W'(1);
        end
    end

    assign row = row_q;
    assign ofs = ofs_q;

endmodule

// File: rtl/pcb_store.sv
module pcb_store
    import pcb_pkg::*;
#(
    parameter int unsigned PAGE_BYTES = 64,
    localparam int unsigned OFS_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_idx,
    input  byte_t            wr_byte,
    input  logic [OFS_W-1:0] rd_idx,
    output byte_t            rd_byte,
    output logic             rd_valid,
    output logic             any_valid
);

    byte_t                 slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;
    logic [PAGE_BYTES-1:0] hit;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_idx == OFS_W'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++) slot_q[i] <= '0;
        end else begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (clr) begin
                    vld_q[i] <= 1'b0;
                end else if (hit[i]) begin
                    vld_q[i]  <= 1'b1;
                    slot_q[i] <= wr_byte;
                end
            end
        end
    end

    assign rd_byte   = slot_q[rd_idx];
    assign rd_valid  = vld_q[rd_idx];
    assign any_valid = |vld_q;

endmodule

// File: rtl/pcb_sequencer.sv
module pcb_sequencer
    import pcb_pkg::*;
#(
    parameter int unsigned PAGE_BYTES   = 64,
    parameter int unsigned WRITE_CYCLES = 20000,
    localparam int unsigned OFS_W = $clog2(PAGE_BYTES),
    localparam int unsigned TMR_W = $clog2(WRITE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  strobe_s          stb,
    input  logic             lock,
    input  logic             any_valid,
    output phase_e           phase,
    output logic [OFS_W-1:0] scan_idx,
    output logic             clr,
    output logic             idle
);

    localparam logic [OFS_W-1:0] LAST_OFS  = OFS_W'(PAGE_BYTES - 1);
    localparam logic [TMR_W-1:0] TMR_START = TMR_W'(WRITE_CYCLES - 1);

    phase_e           ph_q, ph_d;
    logic [OFS_W-1:0] scan_q, scan_d;
    logic [TMR_W-1:0] tmr_q, tmr_d;
    logic             go_commit;

    assign go_commit = stb.stop && any_valid && !lock;

    always_comb begin
        ph_d   = ph_q;
        scan_d = scan_q;
        tmr_d  = tmr_q;
        clr    = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (stb.start || stb.load) begin
                    clr = 1'b1;
                end else if (stb.stop) begin
                    if (go_commit) begin
                        ph_d   = PH_COMMIT;
                        scan_d = '0;
                    end else begin
                        clr = 1'b1;
                    end
                end
            end
            PH_COMMIT: begin
                scan_d = scan_q + OFS_W'(1);
                if (scan_q == LAST_OFS) begin
                    clr   = 1'b1;
                    ph_d  = PH_SETTLE;
                    tmr_d = TMR_START;
                end
            end
            PH_SETTLE: begin
                if (tmr_q == '0) begin
                    ph_d = PH_IDLE;
                end else begin
                    tmr_d = tmr_q - TMR_W'(1);
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            scan_q <= '0;
            tmr_q  <= '0;
        end else begin
            ph_q   <= ph_d;
            scan_q <= scan_d;
            tmr_q  <= tmr_d;
        end
    end

    assign phase    = ph_q;
    assign scan_idx = scan_q;
    assign idle     = (ph_q == PH_IDLE);

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
    import pcb_pkg::*;
#(
    parameter int unsigned PAGE_BYTES   = 64,
    parameter int unsigned PAGE_COUNT   = 512,
    parameter int unsigned WRITE_CYCLES = 20000,
    localparam int unsigned OFS_W  = $clog2(PAGE_BYTES),
    localparam int unsigned ROW_W  = $clog2(PAGE_COUNT),
    localparam int unsigned ADDR_W = OFS_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_addr_i,
    input  logic [ADDR_W-1:0] load_addr_val_i,
    input  logic              byte_stb_i,
    input  logic [7:0]        byte_i,
    input  logic              start_stb_i,
    input  logic              stop_stb_i,
    input  logic              wr_lock_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o,
    output logic              busy_o
);

    strobe_s          raw_stb, acc_stb;
    phase_e           phase;
    logic             idle, clr, any_valid, rd_valid;
    logic [OFS_W-1:0] scan_idx, cur_ofs;
    logic [ROW_W-1:0] cur_row;
    byte_t            rd_byte;

    assign raw_stb.start = start_stb_i;
    assign raw_stb.stop  = stop_stb_i;
    assign raw_stb.load  = load_addr_i;
    assign raw_stb.data  = byte_stb_i;
    assign acc_stb       = gate_strobes(raw_stb, idle);

    pcb_cursor #(
        .OFS_W(OFS_W),
        .ROW_W(ROW_W)
    ) u_cursor (
        .clk     (clk),
        .rst     (rst),
        .load    (acc_stb.load),
        .load_row(load_addr_val_i[ADDR_W-1:OFS_W]),
        .load_ofs(load_addr_val_i[OFS_W-1:0]),
        .adv     (acc_stb.data),
        .row     (cur_row),
        .ofs     (cur_ofs)
    );

    pcb_store #(
        .PAGE_BYTES(PAGE_BYTES)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wr_en    (acc_stb.data),
        .wr_idx   (cur_ofs),
        .wr_byte  (byte_i),
        .rd_idx   (scan_idx),
        .rd_byte  (rd_byte),
        .rd_valid (rd_valid),
        .any_valid(any_valid)
    );

    pcb_sequencer #(
        .PAGE_BYTES  (PAGE_BYTES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stb      (acc_stb),
        .lock     (wr_lock_i),
        .any_valid(any_valid),
        .phase    (phase),
        .scan_idx (scan_idx),
        .clr      (clr),
        .idle     (idle)
    );

    assign mem_we_o   = (phase == PH_COMMIT) && rd_valid;
    assign mem_addr_o = {cur_row, scan_idx};
    assign mem_data_o = rd_byte;
    assign busy_o     = !idle;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
    import pcb_pkg::*;
#(
    parameter int unsigned PAGE_BYTES   = 64,
    parameter int unsigned WRITE_CYCLES = 20000,
    parameter int unsigned OFS_W        = 6,
    parameter int unsigned ADDR_W       = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              stop_stb_i,
    input logic              wr_lock_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              busy_o
);

    localparam int unsigned SPAN = busy_span(PAGE_BYTES, WRITE_CYCLES);

    logic [31:0] span_q;

    always_ff @(posedge clk) begin
        if (rst) span_q <= '0;
        else if (busy_o) span_q <= span_q + 32'd1;
        else span_q <= '0;
    end

    // R6: array writes only inside the busy window
    p_write_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

    // R6: busy window length
    p_busy_span_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (span_q == SPAN));

    // R4: busy only ever follows a stop
    p_busy_after_stop_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_stb_i));

    // R8: write-protected stop raises no busy window
    p_lock_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (stop_stb_i && !busy_o && wr_lock_i) |=> !busy_o);

    // R3: back-to-back writes stay on one page row
    p_row_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |->
        (mem_addr_o[ADDR_W-1:OFS_W] == $past(mem_addr_o[ADDR_W-1:OFS_W])));

    // R4: back-to-back writes step up by one offset
    p_ofs_ascend_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_we_o && $past(mem_we_o)) |->
        (mem_addr_o[OFS_W-1:0] == $past(mem_addr_o[OFS_W-1:0]) + OFS_W'(1)));

endmodule

bind page_commit_buf pcb_checker #(
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES),
    .OFS_W       (OFS_W),
    .ADDR_W      (ADDR_W)
) u_pcb_checker (
    .clk       (clk),
    .rst       (rst),
    .stop_stb_i(stop_stb_i),
    .wr_lock_i (wr_lock_i),
    .mem_we_o  (mem_we_o),
    .mem_addr_o(mem_addr_o),
    .busy_o    (busy_o)
);

// File: tb/page_commit_buf_bench.sv
module page_commit_buf_bench;

    localparam int PERIOD = 10;
    localparam int PB     = 64;
    localparam int PC     = 8;
    localparam int WC     = 30;
    localparam int OW     = $clog2(PB);
    localparam int RW     = $clog2(PC);
    localparam int AW     = OW + RW;
    localparam int MEMSZ  = PB * PC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_addr_i = 1'b0;
    logic [AW-1:0] load_addr_val_i = '0;
    logic          byte_stb_i = 1'b0;
    logic [7:0]    byte_i = '0;
    logic          start_stb_i = 1'b0;
    logic          stop_stb_i = 1'b0;
    logic          wr_lock_i = 1'b0;
    logic          mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_data_o;
    logic          busy_o;

    page_commit_buf #(
        .PAGE_BYTES(PB), .PAGE_COUNT(PC), .WRITE_CYCLES(WC)
    ) u_page_commit_buf (
        .clk(clk), .rst(rst),
        .load_addr_i(load_addr_i), .load_addr_val_i(load_addr_val_i),
        .byte_stb_i(byte_stb_i), .byte_i(byte_i),
        .start_stb_i(start_stb_i), .stop_stb_i(stop_stb_i),
        .wr_lock_i(wr_lock_i),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o), .busy_o(busy_o)
    );

    always #(PERIOD/2) clk = ~clk;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    int   wr_count = 0;
    logic [7:0] act_mem [MEMSZ];
    logic [7:0] exp_mem [MEMSZ];
    logic [7:0] pg_data [PB];
    bit         pg_vld  [PB];
    int         m_row = 0;
    int         m_ofs = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mem_we_o) begin
            act_mem[mem_addr_o] = mem_data_o;
            wr_count++;
        end
    end

    function automatic int valid_count();
        int c = 0;
        for (int i = 0; i < PB; i++) if (pg_vld[i]) c++;
        return c;
    endfunction

    function automatic int mem_mismatches();
        int c = 0;
        for (int i = 0; i < MEMSZ; i++) if (act_mem[i] !== exp_mem[i]) c++;
        return c;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < PB; i++) pg_vld[i] = 0;
    endtask

    task automatic do_load(input int row, input int ofs);
        load_addr_i = 1'b1;
        load_addr_val_i = AW'((row << OW) | ofs);
        @(negedge clk);
        load_addr_i = 1'b0;
        m_row = row; m_ofs = ofs;
        model_clear();
    endtask

    task automatic do_byte(input logic [7:0] b);
        byte_stb_i = 1'b1; byte_i = b;
        @(negedge clk);
        byte_stb_i = 1'b0;
        pg_data[m_ofs] = b; pg_vld[m_ofs] = 1;
        m_ofs = (m_ofs + 1) % PB;
    endtask

    task automatic do_start();
        start_stb_i = 1'b1;
        @(negedge clk);
        start_stb_i = 1'b0;
        model_clear();
    endtask

    // stop: checks commit timing, content and the busy window
    task automatic do_stop(input bit lock, input bit junk, input string req);
        bit expect_commit;
        int n, timing_bad, nvld;
        chk(wr_count == 0, "R4", "writes before stop", wr_count, 0);
        expect_commit = !lock && (valid_count() != 0);
        nvld = valid_count();
        wr_lock_i = lock; stop_stb_i = 1'b1;
        @(negedge clk);
        stop_stb_i = 1'b0; wr_lock_i = 1'b0;
        if (!expect_commit) begin
            chk(busy_o == 1'b0, req, "busy after non-committing stop", busy_o, 0);
            #1;
            chk(wr_count == 0, req, "writes after non-committing stop", wr_count, 0);
        end else begin
            n = 0; timing_bad = 0;
            while (busy_o && n < PB + WC + 10) begin
                n++;
                if (mem_we_o && (int'(mem_addr_o[OW-1:0]) != n - 1 ||
                                 int'(mem_addr_o[AW-1:OW]) != m_row)) timing_bad++;
                if (junk && n >= 3 && n <= 10) begin
                    load_addr_i = 1'b1; load_addr_val_i = AW'($urandom);
                    byte_stb_i = 1'b1; byte_i = 8'($urandom);
                    start_stb_i = (n == 6);
                end else if (junk && n == 11) begin
                    load_addr_i = 1'b0; byte_stb_i = 1'b0; start_stb_i = 1'b0;
                    stop_stb_i = 1'b1;
                end else begin
                    load_addr_i = 1'b0; byte_stb_i = 1'b0;
                    start_stb_i = 1'b0; stop_stb_i = 1'b0;
                end
                @(negedge clk);
            end
            load_addr_i = 1'b0; byte_stb_i = 1'b0; start_stb_i = 1'b0; stop_stb_i = 1'b0;
            chk(n == PB + WC, "R6", "busy window length", n, PB + WC);
            chk(timing_bad == 0, "R4", "write offset vs commit cycle", timing_bad, 0);
            #1;
            chk(wr_count == nvld, "R5", "writes per commit", wr_count, nvld);
            for (int i = 0; i < PB; i++)
                if (pg_vld[i]) exp_mem[m_row * PB + i] = pg_data[i];
        end
        chk(mem_mismatches() == 0, req, "array contents", mem_mismatches(), 0);
        model_clear();
        wr_count = 0;
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMSZ; i++) begin act_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        chk(mem_we_o == 1'b0, "R1", "write enable after reset", mem_we_o, 0);
        // R1 / R10: empty buffer right after reset commits nothing
        do_stop(0, 0, "R1");

        // R2 / R4: single byte partial page write
        do_load(2, 10); do_byte(8'hA5);
        do_stop(0, 0, "R2");

        // R2: short run of consecutive offsets
        do_load(1, 0);
        for (int i = 0; i < 5; i++) do_byte(8'(8'h10 + i));
        do_stop(0, 0, "R2");

        // R3: overflow wraps inside the page, last byte per offset wins
        do_load(3, 60);
        for (int i = 0; i < 70; i++) do_byte(8'(i * 3 + 1));
        do_stop(0, 0, "R3");

        // R8: write protect drops the page
        do_load(4, 0);
        for (int i = 0; i < 5; i++) do_byte(8'hC0 | 8'(i));
        do_stop(1, 0, "R8");
        do_stop(0, 0, "R8");

        // R9: start before stop discards
        do_load(5, 7);
        for (int i = 0; i < 3; i++) do_byte(8'h5A);
        do_start();
        do_stop(0, 0, "R9");

        // R10: address only, then stop
        do_load(1, 5);
        do_stop(0, 0, "R10");

        // R7: traffic during busy is ignored
        do_load(6, 20);
        for (int i = 0; i < 4; i++) do_byte(8'hE0 | 8'(i));
        do_stop(0, 1, "R7");
        do_stop(0, 0, "R7");

        // random sequences
        for (int t = 0; t < 25; t++) begin
            int nb;
            bit lk, dis;
            nb  = 1 + int'($urandom % 80);
            lk  = ($urandom % 4) == 0;
            dis = ($urandom % 5) == 0;
            do_load(int'($urandom % PC), int'($urandom % PB));
            for (int i = 0; i < nb; i++) do_byte(8'($urandom));
            if (dis) begin
                do_start();
                do_stop(lk, 0, "R9");
            end else begin
                do_stop(lk, 0, lk ? "R8" : "R5");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule